// File: doc/BRIEF.md
# External Interrupt Source Selector

This block sits between a bank of general-purpose I/O ports and a shared set of sixteen external-interrupt lines. Each of the nine ports offers sixteen interrupt inputs, one per pin. Output line `n` can be driven by pin `n` of exactly one port at a time. A 4-bit field per output line holds the chosen port number. When a selected input changes level, its new level is forwarded to the output line for its pin. Changes on inputs from ports that are not selected are dropped.

Software programs the block over a simple 32-bit register bus with a 0x400-byte window. Four selector registers each hold four port-select fields. A compensation control word is kept and read back in full. Two further words, for memory remapping and peripheral mode, are present in the map but ignore writes and always read zero. Any other offset is empty.

Top module: `irq_source_router`

## Requirements
- R1: After reset every register reads zero, so every output line selects port 0, and `irqOut` is all zero.
- R2: Selector register k sits at byte offset 0x08 + 4·k (k = 0..3). A write keeps only data bits [15:0], and bits [31:16] read back as zero. For output pin p the field is in register p/4, at bits [(p%4)·4 +: 4].
- R3: Writes to offset 0x00 (remap word) and offset 0x04 (mode word) are ignored, and both offsets always read zero.
- R4: Offset 0x20 (compensation word) stores all 32 written bits and reads them back unchanged.
- R5: A read from any other offset, or from an address with bits [1:0] not zero, returns zero. A write to such an address changes no register.
- R6: Input index i belongs to port i/16 and pin i%16. When the field for pin p holds port number q and input q·16+p takes a new level, `irqOut[p]` shows that level from the first rising clock edge that samples the change.
- R7: A level change on an input whose port is not the one selected for its pin leaves `irqOut` unchanged.
- R8: An output line holds its last forwarded level. Rewriting a selector does not re-sample the inputs. The line only changes on the next level change of the newly selected input.
- R9: A field value of 9 to 15 selects no port, and its output line holds its level whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 10 | Byte address inside the register window |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqIn | input | 144 | Input levels, index = port·16 + pin |
| irqOut | output | 16 | Routed interrupt lines, one per pin |

## Verification
The bench sends level changes from ports that are not selected and checks that each output holds. A design that forwarded every input, or ORed the ports together, would move the line. It rewrites a selector while the newly selected input already sits at the opposite level. A design that re-sampled on the selector change would move the output one event too early. It also programs out-of-range field values 9 to 15, sends wide data to the selector, remap and mode words, and writes to empty or misaligned addresses. Any of those faults shows up as a changed output or a non-zero readback. The random phase mixes all of this with reads of every offset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int SEL_REGS       = 4;
  localparam int FIELD_W        = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int PIN_COUNT      = SEL_REGS * FIELDS_PER_REG;
  localparam int SEL_BITS       = FIELD_W * FIELDS_PER_REG;
  localparam int SEL_IDX_W      = $clog2(SEL_REGS);

  // word indices (byte offset / 4)
  localparam int WIDX_REMAP = 0;
  localparam int WIDX_MODE  = 1;
  localparam int WIDX_SEL0  = 2;
  localparam int WIDX_CMP   = 8;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_SEL  = 2'd1,
    RD_CMP  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic [SEL_REGS-1:0]  selWr;
    logic                 cmpWr;
    rdSrc_e               rdSrc;
    logic [SEL_IDX_W-1:0] rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctlStrobe_t        strobe
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  logic [SEL_REGS-1:0] selHit;
  logic              cmpHit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign cmpHit  = aligned && (wordIdx == WIDX_W'(WIDX_CMP));

  for (genvar k = 0; k < SEL_REGS; k++) begin : g_selDecode
    assign selHit[k] = aligned && (wordIdx == WIDX_W'(WIDX_SEL0 + k));
  end

  always_comb begin
    strobe       = '0;
    strobe.rdSrc = RD_ZERO;
    strobe.selWr = busWe ? selHit : '0;
    strobe.cmpWr = busWe && cmpHit;
    if (cmpHit) strobe.rdSrc = RD_CMP;
    for (int k = 0; k < SEL_REGS; k++) begin
      if (selHit[k]) begin
        strobe.rdSrc = RD_SEL;
        strobe.rdIdx = SEL_IDX_W'(k);
      end
    end
  end

  // R2: at most one selector register is written per cycle
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.selWr));

  // R3: remap and mode words never produce a write strobe
  p_ro_ignore_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (wordIdx == WIDX_W'(WIDX_REMAP) || wordIdx == WIDX_W'(WIDX_MODE)))
      |-> (strobe.selWr == '0 && !strobe.cmpWr));

  // R5: a misaligned address never writes
  p_misaligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr[1:0] != 2'b00) |-> (strobe.selWr == '0 && !strobe.cmpWr));
endmodule

// File: rtl/irq_route_dpath.sv
module irq_route_dpath
  import irq_route_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  input  logic [NUM_PORTS*PIN_COUNT-1:0] irqIn,
  output logic [PIN_COUNT-1:0]           irqOut
);
  localparam int IN_W = NUM_PORTS * PIN_COUNT;

  logic [SEL_BITS-1:0]  selReg [SEL_REGS];
  logic [DATA_W-1:0]    cmpReg;
  logic [IN_W-1:0]      prevIn;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] nextOut;

  // configuration registers
  for (genvar k = 0; k < SEL_REGS; k++) begin : g_selReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                selReg[k] <= '0;
      else if (strobe.selWr[k]) selReg[k] <= busWdata[SEL_BITS-1:0];
    end

    // R2: selector keeps the low half of the written word
    p_sel_store_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.selWr[k] |=> (selReg[k] == $past(busWdata[SEL_BITS-1:0])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmpReg <= '0;
    else if (strobe.cmpWr) cmpReg <= busWdata;
  end

  // routing: forward a change of the selected input only
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [FIELD_W-1:0] field;
    assign field = selReg[p / FIELDS_PER_REG][(p % FIELDS_PER_REG) * FIELD_W +: FIELD_W];

    always_comb begin
      nextOut[p] = outReg[p];
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (field == FIELD_W'(q) && irqIn[q*PIN_COUNT + p] != prevIn[q*PIN_COUNT + p])
          nextOut[p] = irqIn[q*PIN_COUNT + p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
      outReg <= '0;
    end else begin
      prevIn <= irqIn;
      outReg <= nextOut;
    end
  end

  assign irqOut = outReg;

  always_comb begin
    unique case (strobe.rdSrc)
      RD_SEL:  busRdata = DATA_W'(selReg[strobe.rdIdx]);
      RD_CMP:  busRdata = cmpReg;
      default: busRdata = '0;
    endcase
  end

  // R4: compensation word takes the full written value
  p_cmp_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpWr |=> (cmpReg == $past(busWdata)));

  // R2: upper half of a selector read is zero
  p_sel_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSrc == RD_SEL) |-> (busRdata[DATA_W-1:SEL_BITS] == '0));

  // R8: with no input activity the outputs hold, whatever the selectors do
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(irqIn)) |=> $stable(irqOut));
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
  import irq_route_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWe,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  input  logic [NUM_PORTS*PIN_COUNT-1:0] irqIn,
  output logic [PIN_COUNT-1:0]           irqOut
);
  ctlStrobe_t strobe;

  irq_route_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  irq_route_dpath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqIn    (irqIn),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/irq_source_router_bench.sv
`timescale 1ns/1ps
module irq_source_router_bench;
  localparam int NP = 9;
  localparam int NIN = NP * 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [9:0]      busAddr = '0;
  logic            busWe = 1'b0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NIN-1:0]  irqIn = '0;
  logic [15:0]     irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [15:0]    selM [4];
  logic [31:0]    cmpM;
  logic [NIN-1:0] prevM;
  logic [15:0]    outM;
  logic [NIN-1:0] inV;

  always #2.5 clk = ~clk;

  irq_source_router u_irq_source_router (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fieldOf(input int p);
    logic [15:0] r;
    r = selM[p/4];
    return r[(p%4)*4 +: 4];
  endfunction

  function automatic logic [31:0] expRead(input logic [9:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[9:2])
      8'd2, 8'd3, 8'd4, 8'd5: return {16'h0, selM[a[9:2]-8'd2]};
      8'd8:                   return cmpM;
      default:                return 32'h0;
    endcase
  endfunction

  // model of one rising edge: routing uses selectors before the write
  task automatic modelEdge(input logic we, input logic [9:0] a, input logic [31:0] d,
                           input logic [NIN-1:0] v);
    for (int p = 0; p < 16; p++) begin
      int q;
      q = int'(fieldOf(p));
      if (q < NP && v[q*16+p] != prevM[q*16+p]) outM[p] = v[q*16+p];
    end
    prevM = v;
    if (we && a[1:0] == 2'b00) begin
      if (a[9:2] >= 8'd2 && a[9:2] <= 8'd5) selM[a[9:2]-8'd2] = d[15:0];
      else if (a[9:2] == 8'd8) cmpM = d;
    end
  endtask

  task automatic cycle(input string tag, input logic we, input logic [9:0] a,
                       input logic [31:0] d, input logic [NIN-1:0] v);
    busWe = we; busAddr = a; busWdata = d; irqIn = v;
    @(posedge clk);
    modelEdge(we, a, d, v);
    @(negedge clk);
    busWe = 1'b0;
    check(tag, {16'h0, irqOut}, {16'h0, outM});
  endtask

  task automatic rd(input string tag, input logic [9:0] a);
    busAddr = a;
    #1;
    check(tag, busRdata, expRead(a));
  endtask

  initial begin
    for (int k = 0; k < 4; k++) selM[k] = '0;
    cmpM = '0; prevM = '0; outM = '0; inV = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irqOut after reset", {16'h0, irqOut}, 32'h0);
    for (int a = 0; a < 10; a++) begin
      busAddr = 10'(a * 4); #1;
      check("R1 register after reset", busRdata, 32'h0);
    end

    // R2: selector keeps low half
    cycle("R2 write", 1'b1, 10'h008, 32'hDEAD_BEEF, inV);
    busAddr = 10'h008; #1; check("R2 selector low half", busRdata, 32'h0000_BEEF);
    cycle("R2 write", 1'b1, 10'h014, 32'h1234_5678, inV);
    busAddr = 10'h014; #1; check("R2 selector 3", busRdata, 32'h0000_5678);

    // R3: remap and mode ignore writes
    cycle("R3 write", 1'b1, 10'h000, 32'hFFFF_FFFF, inV);
    cycle("R3 write", 1'b1, 10'h004, 32'hFFFF_FFFF, inV);
    busAddr = 10'h000; #1; check("R3 remap reads zero", busRdata, 32'h0);
    busAddr = 10'h004; #1; check("R3 mode reads zero", busRdata, 32'h0);

    // R4: compensation full word
    cycle("R4 write", 1'b1, 10'h020, 32'hA5A5_5A5A, inV);
    busAddr = 10'h020; #1; check("R4 compensation readback", busRdata, 32'hA5A5_5A5A);

    // R5: unmapped and misaligned
    cycle("R5 write", 1'b1, 10'h018, 32'hFFFF_FFFF, inV);
    cycle("R5 write", 1'b1, 10'h3FC, 32'hFFFF_FFFF, inV);
    cycle("R5 write", 1'b1, 10'h021, 32'h0000_0000, inV);
    cycle("R5 write", 1'b1, 10'h009, 32'h0000_0000, inV);
    busAddr = 10'h018; #1; check("R5 unmapped reads zero", busRdata, 32'h0);
    busAddr = 10'h022; #1; check("R5 misaligned reads zero", busRdata, 32'h0);
    busAddr = 10'h020; #1; check("R5 compensation untouched", busRdata, 32'hA5A5_5A5A);
    busAddr = 10'h008; #1; check("R5 selector untouched", busRdata, 32'h0000_BEEF);

    // R6: pin 1 on port 3, pin 0 on port 0
    cycle("R6 write", 1'b1, 10'h008, 32'h0000_0030, inV);
    inV[3*16+1] = 1'b1;
    cycle("R6 routing", 1'b0, 10'h0, 32'h0, inV);
    check("R6 pin1 follows port3", {31'h0, irqOut[1]}, 32'h1);
    inV[3*16+1] = 1'b0;
    cycle("R6 routing", 1'b0, 10'h0, 32'h0, inV);
    check("R6 pin1 falls with port3", {31'h0, irqOut[1]}, 32'h0);

    // R7: non-selected port for pin 1
    inV[1] = 1'b1; inV[5*16+1] = 1'b1;
    cycle("R7 drop", 1'b0, 10'h0, 32'h0, inV);
    check("R7 unselected ports ignored", {31'h0, irqOut[1]}, 32'h0);

    // R8: switch pin 1 to port 0 while its input is high: no re-sample
    cycle("R8 write", 1'b1, 10'h008, 32'h0000_0000, inV);
    cycle("R8 idle", 1'b0, 10'h0, 32'h0, inV);
    check("R8 no re-sample on selector change", {31'h0, irqOut[1]}, 32'h0);
    inV[1] = 1'b0;
    cycle("R8 event", 1'b0, 10'h0, 32'h0, inV);
    inV[1] = 1'b1;
    cycle("R8 event", 1'b0, 10'h0, 32'h0, inV);
    check("R8 follows new port after change", {31'h0, irqOut[1]}, 32'h1);

    // R9: pin 2 field 0xC selects nothing
    cycle("R9 write", 1'b1, 10'h008, 32'h0000_0C00, inV);
    for (int q = 0; q < NP; q++) inV[q*16+2] = 1'b1;
    cycle("R9 drop", 1'b0, 10'h0, 32'h0, inV);
    check("R9 out-of-range field holds", {31'h0, irqOut[2]}, 32'h0);
    cycle("R9 write", 1'b1, 10'h008, 32'h0000_0F00, inV);
    for (int q = 0; q < NP; q++) inV[q*16+2] = 1'b0;
    cycle("R9 drop", 1'b0, 10'h0, 32'h0, inV);
    for (int q = 0; q < NP; q++) inV[q*16+2] = 1'b1;
    cycle("R9 drop", 1'b0, 10'h0, 32'h0, inV);
    check("R9 field 0xF holds", {31'h0, irqOut[2]}, 32'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [9:0] a;
      logic [31:0] d;
      op = int'($urandom % 6);
      case ($urandom % 8)
        0: a = 10'h000; 1: a = 10'h004; 2: a = 10'h008; 3: a = 10'h00C;
        4: a = 10'h010; 5: a = 10'h014; 6: a = 10'h020;
        default: a = 10'($urandom);
      endcase
      d = $urandom;
      if (op == 0) begin
        cycle("R2 random write", 1'b1, a, d, inV);
      end else if (op == 5) begin
        rd("R5 random read", a);
        cycle("R8 random idle", 1'b0, 10'h0, 32'h0, inV);
      end else begin
        for (int b = 0; b < op; b++) inV ^= (NIN'(1) << ($urandom % NIN));
        cycle("R6 random inputs", 1'b0, 10'h0, 32'h0, inV);
      end
    end
    for (int a = 0; a < 12; a++) rd("R4 final readback", 10'(a * 4));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule